// File: doc/BRIEF.md
# Two-Wire Serial Configuration Register Bank

This block is a two-wire serial target that holds sixteen 8-bit configuration registers and exposes all of them at once on a flat parallel bus. Downstream logic reads that bus directly. A host sets or reads the registers over SCL and SDA. SDA is open-drain: the block sees the line level on an input and pulls it low through an enable output. Both bus lines are resampled into a faster system clock through two flip-flops before any decoding takes place.

A host writes a burst by addressing the device with the direction bit clear, sending one byte that selects a register, and then streaming data bytes. Each data byte lands in the selected register at the moment the block acknowledges it. A host reads with a combined transfer. It first sets the pointer in a write, then issues a repeated START and the device address with the direction bit set, and then clocks out bytes. A read covers at most one full pass over the bank, beginning at the pointed register and wrapping round to register 0.

Top module: `cfg_regbank_i2c`

## Requirements
- R1: After reset every register reads 0x00 on `regs_o` and `sda_oe` is low (SDA released).
- R2: The block acknowledges (pulls SDA low in the ninth clock) only when the first seven bits after a START equal `DEV_ADDR`. On a mismatch it leaves SDA released, and no register changes until the next START.
- R3: With direction bit 0 (write), the next byte's low 4 bits load the pointer and that byte is acknowledged. Each following data byte is acknowledged and written to register `ptr`, which appears on `regs_o[8*ptr+7 : 8*ptr]`, and then the pointer advances by one.
- R4: A data byte is committed when its acknowledge is driven, before any STOP, so the earlier bytes of a burst are already visible while later ones are still arriving.
- R5: During writes the pointer wraps from register 15 to register 0.
- R6: After a repeated START and the device address with direction bit 1, the block acknowledges. It then sends the register at the pointer set before the repeated START, MSB first, and advances the pointer after each byte.
- R7: One read returns at most sixteen bytes, wrapping past register 15 to 0. After the sixteenth byte SDA stays released, so any further byte reads as 0xFF.
- R8: When the host does not acknowledge a read byte, the block releases SDA for the rest of the transfer, and a further byte reads as 0xFF.
- R9: A START or STOP inside a byte abandons it. A partial byte is never written, and a START always releases SDA on the next cycle.
- R10: SDA bits are sampled on rising SCL, and the block changes `sda_oe` only after a falling SCL edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| regs_o | output | NREG*DW | All registers, register n in bits [DW*n+DW-1 : DW*n] |

## Verification
The embedded assertions cover the properties that hold on every cycle. They check that the SDA enable moves only after a falling SCL, a START or a STOP, that each commit coincides with driving an acknowledge, that the register bus holds steady when no write is strobed, that a START releases SDA, and that a read never counts beyond sixteen bytes. Only the directed scenarios can show the transfer-level outcomes: the actual values written and their positions, pointer wrap in both directions, the pointer surviving a repeated START, mismatch and abort leaving registers untouched, and the released line after a NACK or a full sweep.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_ACKDEV, S_REG, S_ACKREG,
    S_WDATA, S_ACKWR, S_RDATA, S_RACK
  } rb_state_t;

  // Pointer advance with wrap at the bank size.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_ff[1] & ~scl_q;
  assign scl_fall  = ~scl_ff[1] & scl_q;
  assign start_det = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
  assign stop_det  = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];

endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 8,
  parameter int AW   = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [AW-1:0]      raddr,
  output logic [DW-1:0]      rdata,
  output logic [NREG*DW-1:0] flat
);
  logic [DW-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mem[i] <= '0;
      else if (we && waddr == AW'(i))    mem[i] <= wdata;
    end
    assign flat[i*DW +: DW] = mem[i];
  end

  assign rdata = mem[raddr];

  // R3: contents move only on a write strobe
  a_r3_hold_without_we: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(flat));

endmodule

// File: rtl/cfg_regbank_i2c.sv
module cfg_regbank_i2c #(
  parameter logic [6:0] DEV_ADDR = 7'h52,
  parameter int         NREG     = 16,
  parameter int         DW       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NREG*DW-1:0] regs_o
);
  import i2c_rb_pkg::*;

  localparam int AW = $clog2(NREG);
  localparam int BW = $clog2(DW + 1);
  localparam int CW = $clog2(NREG + 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  rb_state_t     st;
  logic [BW-1:0] bitcnt;
  logic [DW-1:0] shreg, txsh, rd_data;
  logic [AW-1:0] ptr;
  logic [CW-1:0] sent;
  logic          rw, oe_q, wr_en, byte_done;

  i2c_rb_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return AW'(wrap_inc(32'(p), NREG));
  endfunction

  assign byte_done = scl_fall && (bitcnt == BW'(DW)) && !start_det && !stop_det;
  assign wr_en     = (st == S_WDATA) && byte_done;

  i2c_rb_regfile #(.NREG(NREG), .DW(DW), .AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(ptr), .wdata(shreg),
    .raddr(ptr), .rdata(rd_data), .flat(regs_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txsh   <= '0;
      ptr    <= '0;
      sent   <= '0;
      rw     <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start_det) begin
      st     <= S_DEV;
      bitcnt <= '0;
      oe_q   <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      oe_q   <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_REG, S_WDATA: begin
          if (scl_rise && bitcnt != BW'(DW)) begin
            shreg  <= {shreg[DW-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            bitcnt <= '0;
            if (st == S_DEV) begin
              if (shreg[DW-1:1] == DEV_ADDR) begin
                rw   <= shreg[0];
                oe_q <= 1'b1;
                st   <= S_ACKDEV;
              end else begin
                st   <= S_IDLE;
              end
            end else if (st == S_REG) begin
              ptr  <= shreg[AW-1:0];
              oe_q <= 1'b1;
              st   <= S_ACKREG;
            end else begin
              ptr  <= ptr_next(ptr);
              oe_q <= 1'b1;
              st   <= S_ACKWR;
            end
          end
        end
        S_ACKDEV: if (scl_fall) begin
          if (rw) begin
            txsh <= rd_data;
            oe_q <= ~rd_data[DW-1];
            sent <= '0;
            st   <= S_RDATA;
          end else begin
            oe_q <= 1'b0;
            st   <= S_REG;
          end
        end
        S_ACKREG, S_ACKWR: if (scl_fall) begin
          oe_q <= 1'b0;
          st   <= S_WDATA;
        end
        S_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == BW'(DW)) begin
              oe_q   <= 1'b0;
              bitcnt <= '0;
              ptr    <= ptr_next(ptr);
              sent   <= sent + 1'b1;
              st     <= S_RACK;
            end else begin
              txsh <= {txsh[DW-2:0], 1'b0};
              oe_q <= ~txsh[DW-2];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            if (sda_s) st <= S_IDLE;
          end else if (scl_fall) begin
            if (sent == CW'(NREG)) begin
              st <= S_IDLE;
            end else begin
              txsh <= rd_data;
              oe_q <= ~rd_data[DW-1];
              st   <= S_RDATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;

  // R10: the target starts pulling SDA only after SCL has fallen
  a_r10_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
  // R10: release happens only after a falling SCL, START or STOP
  a_r10_release_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));
  // R4: each commit is accompanied by the acknowledge
  a_r4_ack_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);
  // R9: a START frees the line
  a_r9_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
  // R7: a read never counts past one full sweep
  a_r7_sweep_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sent <= CW'(NREG));

endmodule

// File: tb/sim_cfg_regbank_i2c.sv
module sim_cfg_regbank_i2c;
  localparam logic [6:0] DEV = 7'h52;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [127:0] regs_o;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  cfg_regbank_i2c #(.DEV_ADDR(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mdl [16];

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic qd(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; qd(); scl = 1'b1; qd(); sda_m = 1'b0; qd(); scl = 1'b0; qd();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qd(); scl = 1'b1; qd(); sda_m = 1'b1; qd();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qd(); scl = 1'b1; qd(); qd(); scl = 1'b0; qd();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; qd(); scl = 1'b1; qd(); ack = ~sda_line; qd(); scl = 1'b0; qd();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qd(); scl = 1'b1; qd(); d[i] = sda_line; qd(); scl = 1'b0; qd();
    end
    sda_m = ~give_ack; qd(); scl = 1'b1; qd(); qd(); scl = 1'b0; qd(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] reg_at(input int n);
    return regs_o[n*8 +: 8];
  endfunction

  task automatic t_reset();
    check("R1 regs zero", regs_o[31:0] | regs_o[63:32] | regs_o[95:64] | regs_o[127:96], 0);
    check("R1 sda released", sda_oe, 0);
  endtask

  task automatic t_write_burst();
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a); check("R2 addr ack", a, 1);
    send_byte(8'h02, a);       check("R3 regaddr ack", a, 1);
    send_byte(8'hA1, a);       check("R3 data ack", a, 1);
    check("R4 reg2 before stop", reg_at(2), 8'hA1);
    check("R4 reg3 not yet", reg_at(3), 8'h00);
    send_byte(8'hB2, a);
    send_byte(8'hC3, a);       check("R3 data ack 3", a, 1);
    bus_stop();
    mdl[2] = 8'hA1; mdl[3] = 8'hB2; mdl[4] = 8'hC3;
    check("R3 reg3", reg_at(3), 8'hB2);
    check("R3 reg4", reg_at(4), 8'hC3);
  endtask

  task automatic t_wrap_write();
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h3E, a);   // low 4 bits select register 14
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a); send_byte(8'h44, a);
    bus_stop();
    mdl[14] = 8'h11; mdl[15] = 8'h22; mdl[0] = 8'h33; mdl[1] = 8'h44;
    check("R3 low bits reg14", reg_at(14), 8'h11);
    check("R5 reg15", reg_at(15), 8'h22);
    check("R5 wrap reg0", reg_at(0), 8'h33);
    check("R5 wrap reg1", reg_at(1), 8'h44);
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a); check("R2 mismatch nack", a, 0);
    send_byte(8'h05, a); check("R2 ignored regaddr", a, 0);
    send_byte(8'hEE, a);
    bus_stop();
    check("R2 reg5 untouched", reg_at(5), 8'h00);
  endtask

  task automatic t_abort();
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h06, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_stop();
    check("R9 stop aborts byte", reg_at(6), 8'h00);
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h07, a);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    check("R9 start releases", sda_oe, 0);
    send_byte({DEV, 1'b0}, a); check("R9 restart acked", a, 1);
    bus_stop();
    check("R9 start aborts byte", reg_at(7), 8'h00);
  endtask

  task automatic t_read_sweep();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h0D, a);
    bus_start();
    send_byte({DEV, 1'b1}, a); check("R6 read addr ack", a, 1);
    for (int i = 0; i < 16; i++) begin
      recv_byte(1'b1, d);
      check($sformatf("R6 R7 byte %0d", i), d, mdl[(13 + i) % 16]);
    end
    recv_byte(1'b0, d); check("R7 beyond sweep", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_read_nack();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h02, a);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, d); check("R6 first byte", d, mdl[2]);
    check("R8 released after nack", sda_oe, 0);
    recv_byte(1'b0, d); check("R8 line idle after nack", d, 8'hFF);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_write_burst();
    t_wrap_write();
    t_wrong_addr();
    t_abort();
    t_read_sweep();
    t_read_nack();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule